// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Bank

This block holds the configuration and status state of a small SDRAM controller. Software reaches it through a single register port that exposes only two locations. One is an 8-bit pointer. The other is a 32-bit data window, and every window access goes to the internal register that the pointer currently selects. Each internal register applies its own write mask or forced bits. Turning the controller's enable bit on or off, or its self-refresh request bit, updates flags in a read-only status register.

The block also raises an interrupt while the ECC error status register is nonzero. It keeps a set of bank configuration registers, each holding a base address, a size code and a valid flag. A combinational probe compares an input address against every bank and reports a hit together with the index of the bank that was hit.

Top module: `sdram_cfg_regs`

## Requirements
- R1: With `bus_win`=0 a write loads the 8-bit pointer, and a read returns it zero-extended to 32 bits. With `bus_win`=1, reads and writes go to the internal register at the pointer offset.
- R2: After reset, config reads 0x00800000, power management 0x07C00000 and refresh 0x05F00000. Status, ECC status, ECC config, error address and all bank registers read 0. `ecc_irq` and `probe_hit` are 0.
- R3: Config (offset 0x20) stores data AND 0xFFE00000. When config bit 31 goes 0→1, status bit 31 is cleared; when it goes 1→0, status bit 31 is set. When config bit 30 goes 0→1, status bit 30 is set; when it goes 1→0, status bit 30 is cleared.
- R4: Refresh (0x30) stores data AND 0x3FF80000, and ECC config (0x94) stores data AND 0x00F00000. Power management (0x34) stores (data AND 0xF8000000) OR 0x07C00000. Error address (0x10) stores all 32 bits.
- R5: Status (0x24) is read-only: a window write to it leaves it unchanged. The two error status registers (0x00, 0x08) are write-one-to-clear and, having no error source here, read 0 after any write.
- R6: ECC status (0x98) stores data AND 0xFFF0F000. `ecc_irq` rises when this register goes from zero to nonzero, falls when it goes from nonzero to zero, and otherwise holds.
- R7: Bank registers at 0x40, 0x44, 0x48 and 0x4C (banks 0 to 3) store data AND 0xFFDEE001. In each, bit 0 is the valid flag, bits 31:23 are the base address and bits 19:17 are the size code.
- R8: A window read at the timing offset (0x80), or at any offset with no register, returns 0xFFFFFFFF.
- R9: `probe_hit` is 1 only when config bit 31 is set and some bank is valid with `probe_addr` in [base, base + (4 MiB << code)). The lower bound is inclusive and the upper bound exclusive.
- R10: A bank whose size code is 7 never hits.
- R11: When several banks match, `probe_bank` gives the lowest-numbered one. It is 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_win | input | 1 | 0 selects the pointer, 1 selects the data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected location (combinational) |
| probe_addr | input | 32 | Address checked against the banks |
| probe_hit | output | 1 | Probe address falls in an enabled, valid bank |
| probe_bank | output | 2 | Index of the winning bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Every register update, the status side effects and `ecc_irq` take effect at the clock edge that samples `bus_wr`. Read data and the probe outputs are combinational from the stored state. The bench therefore drives on the falling edge. It reads a window value after the pointer write's rising edge and a short settle delay, and it samples `ecc_irq` and the probe outputs half a cycle after the edge that committed the write. It never samples at the edge itself.

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs #(
  parameter int NUM_BANKS = 4,
  parameter int PTR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_win,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [31:0]             probe_addr,
  output logic                    probe_hit,
  output logic [((NUM_BANKS>1)?$clog2(NUM_BANKS):1)-1:0] probe_bank,
  output logic                    ecc_irq
);
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [PTR_W-1:0] A_BERR0 = PTR_W'(8'h00);
  localparam logic [PTR_W-1:0] A_BERR1 = PTR_W'(8'h08);
  localparam logic [PTR_W-1:0] A_EADDR = PTR_W'(8'h10);
  localparam logic [PTR_W-1:0] A_CFG   = PTR_W'(8'h20);
  localparam logic [PTR_W-1:0] A_STAT  = PTR_W'(8'h24);
  localparam logic [PTR_W-1:0] A_RFSH  = PTR_W'(8'h30);
  localparam logic [PTR_W-1:0] A_PWR   = PTR_W'(8'h34);
  localparam logic [PTR_W-1:0] A_BANK  = PTR_W'(8'h40);
  localparam logic [PTR_W-1:0] A_ECFG  = PTR_W'(8'h94);
  localparam logic [PTR_W-1:0] A_ESTAT = PTR_W'(8'h98);

  logic [PTR_W-1:0] ptr_q;
  logic [31:0] berr0_q, berr1_q, eaddr_q, cfg_q, stat_q, rfsh_q, pwr_q, ecfg_q, estat_q;
  logic [31:0] bank_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic [31:0] win_rd;

  wire win_wr = bus_wr & bus_win;
  wire [31:0] cfg_new = bus_wdata & 32'hFFE0_0000;
  wire [31:0] est_new = bus_wdata & 32'hFFF0_F000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      berr0_q <= '0;
      berr1_q <= '0;
      eaddr_q <= '0;
      cfg_q   <= 32'h0080_0000;
      stat_q  <= '0;
      rfsh_q  <= 32'h05F0_0000;
      pwr_q   <= 32'h07C0_0000;
      ecfg_q  <= '0;
      estat_q <= '0;
      ecc_irq <= 1'b0;
    end else if (bus_wr && !bus_win) begin
      ptr_q <= bus_wdata[PTR_W-1:0];
    end else if (win_wr) begin
      case (ptr_q)
        A_BERR0: berr0_q <= berr0_q & ~bus_wdata;
        A_BERR1: berr1_q <= berr1_q & ~bus_wdata;
        A_EADDR: eaddr_q <= bus_wdata;
        A_CFG: begin
          if (!cfg_q[31] && cfg_new[31]) stat_q[31] <= 1'b0;
          else if (cfg_q[31] && !cfg_new[31]) stat_q[31] <= 1'b1;
          if (!cfg_q[30] && cfg_new[30]) stat_q[30] <= 1'b1;
          else if (cfg_q[30] && !cfg_new[30]) stat_q[30] <= 1'b0;
          cfg_q <= cfg_new;
        end
        A_RFSH: rfsh_q <= bus_wdata & 32'h3FF8_0000;
        A_PWR:  pwr_q  <= (bus_wdata & 32'hF800_0000) | 32'h07C0_0000;
        A_ECFG: ecfg_q <= bus_wdata & 32'h00F0_0000;
        A_ESTAT: begin
          if (estat_q == '0 && est_new != '0) ecc_irq <= 1'b1;
          else if (estat_q != '0 && est_new == '0) ecc_irq <= 1'b0;
          estat_q <= est_new;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [PTR_W-1:0] OFF = PTR_W'(A_BANK + PTR_W'(4 * g));
    logic [31:0] base;
    logic [2:0]  code;
    logic [32:0] lim;

    always_ff @(posedge clk) begin
      if (!rst_n) bank_q[g] <= '0;
      else if (win_wr && ptr_q == OFF) bank_q[g] <= bus_wdata & 32'hFFDE_E001;
    end

    assign base = {bank_q[g][31:23], 23'b0};
    assign code = bank_q[g][19:17];
    assign lim  = {1'b0, base} + (33'd1 << (22 + code));
    assign bank_hit[g] = cfg_q[31] & bank_q[g][0] & (code != 3'd7) &
                         (probe_addr >= base) & ({1'b0, probe_addr} < lim);
  end

  always_comb begin
    probe_hit  = 1'b0;
    probe_bank = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (bank_hit[i]) begin
        probe_hit  = 1'b1;
        probe_bank = BW'(i);
      end
    end
  end

  always_comb begin
    case (ptr_q)
      A_BERR0: win_rd = berr0_q;
      A_BERR1: win_rd = berr1_q;
      A_EADDR: win_rd = eaddr_q;
      A_CFG:   win_rd = cfg_q;
      A_STAT:  win_rd = stat_q;
      A_RFSH:  win_rd = rfsh_q;
      A_PWR:   win_rd = pwr_q;
      A_ECFG:  win_rd = ecfg_q;
      A_ESTAT: win_rd = estat_q;
      default: win_rd = '1;
    endcase
    for (int i = 0; i < NUM_BANKS; i++)
      if (ptr_q == PTR_W'(A_BANK + PTR_W'(4 * i))) win_rd = bank_q[i];
  end

  assign bus_rdata = bus_win ? win_rd : {{(32-PTR_W){1'b0}}, ptr_q};

  // R6
  ecc_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_irq == (estat_q != '0));
  // R5
  stat_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && ptr_q == A_STAT) |=> $stable(stat_q));
  // R4
  pwr_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q[26:22] == 5'h1F);
  // R3
  cfg_en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[31]) |-> stat_q[31]);
  // R9
  hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> cfg_q[31]);
  // R11
  bank_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_hit |-> probe_bank == '0);
endmodule

// File: tb/sdram_cfg_regs_tb.sv
module sdram_cfg_regs_tb_top;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_win = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, probe_addr = 0;
  logic probe_hit, ecc_irq;
  logic [1:0] probe_bank;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_win(bus_win),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_addr(probe_addr),
    .probe_hit(probe_hit), .probe_bank(probe_bank), .ecc_irq(ecc_irq));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(bit win, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_win = win; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] off, output logic [31:0] v);
    wr(0, {24'b0, off});
    bus_win = 1;
    #1 v = bus_rdata;
  endtask

  task automatic wreg(logic [7:0] off, logic [31:0] d);
    wr(0, {24'b0, off});
    wr(1, d);
  endtask

  task automatic expect_reg(string req, logic [7:0] off, logic [31:0] exp);
    logic [31:0] v;
    rd(off, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R2 cfg", 8'h20, 32'h0080_0000);
    expect_reg("R2 pwr", 8'h34, 32'h07C0_0000);
    expect_reg("R2 rfsh", 8'h30, 32'h05F0_0000);
    expect_reg("R2 stat", 8'h24, 0);
    expect_reg("R2 estat", 8'h98, 0);
    expect_reg("R2 bank0", 8'h40, 0);
    chk("R2 irq", ecc_irq, 0);
    chk("R2 hit", probe_hit, 0);
  endtask

  task automatic t_pointer;
    wr(0, 32'hFFFF_FFA5);
    bus_win = 0;
    #1 chk("R1 ptr readback", bus_rdata, 32'h0000_00A5);
    wreg(8'h10, 32'hDEAD_BEEF);
    expect_reg("R1/R4 eaddr", 8'h10, 32'hDEAD_BEEF);
  endtask

  task automatic t_cfg;
    wreg(8'h20, 32'hFFFF_FFFF);
    expect_reg("R3 cfg mask", 8'h20, 32'hFFE0_0000);
    expect_reg("R3 stat rise", 8'h24, 32'h4000_0000);
    wreg(8'h20, 32'h0000_0000);
    expect_reg("R3 stat fall", 8'h24, 32'h8000_0000);
    wreg(8'h20, 32'h8000_0000);
    expect_reg("R3 stat en", 8'h24, 32'h0000_0000);
  endtask

  task automatic t_masks;
    wreg(8'h30, 32'hFFFF_FFFF);
    expect_reg("R4 rfsh", 8'h30, 32'h3FF8_0000);
    wreg(8'h94, 32'hFFFF_FFFF);
    expect_reg("R4 ecfg", 8'h94, 32'h00F0_0000);
    wreg(8'h34, 32'h0);
    expect_reg("R4 pwr0", 8'h34, 32'h07C0_0000);
    wreg(8'h34, 32'hFFFF_FFFF);
    expect_reg("R4 pwr1", 8'h34, 32'hFFC0_0000);
    wreg(8'h24, 32'hFFFF_FFFF);
    expect_reg("R5 stat ro", 8'h24, 32'h0000_0000);
    wreg(8'h00, 32'hFFFF_FFFF);
    expect_reg("R5 berr0", 8'h00, 0);
    wreg(8'h08, 32'h1234_5678);
    expect_reg("R5 berr1", 8'h08, 0);
    wreg(8'h4C, 32'hFFFF_FFFF);
    expect_reg("R7 bank mask", 8'h4C, 32'hFFDE_E001);
    expect_reg("R8 timing", 8'h80, 32'hFFFF_FFFF);
    expect_reg("R8 unknown", 8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_ecc;
    wreg(8'h98, 32'hFFFF_FFFF);
    #1 chk("R6 irq up", ecc_irq, 1);
    expect_reg("R6 estat mask", 8'h98, 32'hFFF0_F000);
    wreg(8'h98, 32'h000F_0FFF);
    #1 chk("R6 irq masked zero", ecc_irq, 0);
    wreg(8'h98, 32'h0000_1000);
    #1 chk("R6 irq up2", ecc_irq, 1);
    wreg(8'h98, 32'h0000_2000);
    #1 chk("R6 irq hold", ecc_irq, 1);
    wreg(8'h98, 32'h0);
    #1 chk("R6 irq down", ecc_irq, 0);
  endtask

  task automatic probe(string req, logic [31:0] a, bit h, logic [1:0] b);
    @(negedge clk);
    probe_addr = a;
    #1;
    chk(req, probe_hit, h);
    chk(req, probe_bank, b);
  endtask

  task automatic t_hit;
    wreg(8'h20, 32'h0);
    wreg(8'h40, 32'h0004_0001);
    wreg(8'h44, 32'h0080_0001);
    wreg(8'h48, 32'h020E_0001);
    wreg(8'h4C, 32'h0402_0001);
    probe("R9 disabled", 32'h0000_0000, 0, 0);
    wreg(8'h20, 32'h8000_0000);
    probe("R9 base incl", 32'h0000_0000, 1, 0);
    probe("R11 overlap", 32'h0090_0000, 1, 0);
    probe("R9 upper excl", 32'h0100_0000, 0, 0);
    probe("R10 code7", 32'h0200_0000, 0, 0);
    probe("R9 bank3 top", 32'h047F_FFFF, 1, 3);
    probe("R9 bank3 end", 32'h0480_0000, 0, 0);
    wreg(8'h40, 32'h0004_0000);
    probe("R11 next bank", 32'h0090_0000, 1, 1);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_pointer;
    t_cfg;
    t_masks;
    t_ecc;
    t_hit;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule